// File: doc/BRIEF.md
# Half-Duplex Serial Transceiver with Deferred Line Release

This block is a byte-oriented serial transceiver for one data wire that both ends share, such as a bus of daisy-chained actuators. A single queued transmit path has a one-byte holding register that feeds a shift register. A receiver samples the same wire and stores incoming bytes in a small indexed buffer. Software-style control bits select transmit enable, receive enable and receive interrupt enable.

The key property is how the block hands the wire back. Clearing transmit enable does not cut off the driver. It records a release request, and the output driver stays on until the holding register and the shift register have both emptied. Only then is the wire released, so the remote device can answer. Software can therefore queue the last bytes of a command and request the turnaround at once, without timing the final stop bit itself. A one-shot turnaround input does the same thing as a control write that clears transmit enable and sets receive enable and receive interrupt enable. It also rewinds the receive buffer so that the reply lands at index zero.

Top module: `hd_uart`

## Requirements
- R1: After reset, `line_oe_o` is 0, `line_o` is 1, `tx_full_o` is 0, `rx_count_o` is 0 and `rx_irq_o` is 0.
- R2: Each transmitted character is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts `div_i` clocks. A byte already waiting in the holding register starts the moment the previous stop bit ends, with no idle gap.
- R3: `line_oe_o` stays 1 while a byte sits in the holding register or is being shifted, even after transmit enable has been cleared.
- R4: Once transmit enable is clear, `line_oe_o` falls one clock after the stop bit of the last queued byte ends. If nothing is queued, it falls one clock after the control write that clears transmit enable.
- R5: A transmit write made while transmit enable is clear is dropped: `tx_full_o` stays 0 and no character appears.
- R6: Setting transmit enable again before the queue drains cancels the pending release, and `line_oe_o` stays 1 after the last byte.
- R7: With receive enabled, the receiver confirms a start bit half a bit after the falling edge and samples each later bit at mid-bit. It stores bytes in arrival order at indices 0, 1, 2 and so on, and `rx_count_o` counts them.
- R8: While `line_oe_o` is 1 the receiver ignores the wire, so the block's own characters are never stored.
- R9: With receive enable clear, characters on the wire are not stored.
- R10: A pulse on `turn_rx_i` clears transmit enable as a pending request, sets receive enable and receive interrupt enable, and clears `rx_count_o` and `rx_ovf_o`. A control write that raises receive enable from 0 to 1 also clears them.
- R11: `rx_irq_o` pulses for one clock for each stored byte when receive interrupt enable is set, and stays 0 when it is clear.
- R12: A stop bit sampled low marks that byte's entry with a framing error (`rd_ferr_o` = 1). The receiver then waits for the wire to return high before it looks for another start bit.
- R13: `rx_count_o` saturates at the buffer depth (8 by default). A byte arriving when the buffer is full is dropped and sets the sticky `rx_ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Clocks per bit, at least 4 |
| ctrl_we_i | input | 1 | Writes the three control bits below |
| ctrl_tx_en_i | input | 1 | Transmit enable value to write |
| ctrl_rx_en_i | input | 1 | Receive enable value to write |
| ctrl_rx_ie_i | input | 1 | Receive interrupt enable value to write |
| turn_rx_i | input | 1 | One-shot switch to receive; takes priority over a control write |
| tx_wr_i | input | 1 | Writes `tx_data_i` into the holding register |
| tx_data_i | input | 8 | Byte to send |
| tx_full_o | output | 1 | Holding register occupied |
| line_i | input | 1 | Shared wire as seen at the pad |
| line_o | output | 1 | Value driven onto the wire |
| line_oe_o | output | 1 | Driver enable; 0 means the wire is released for receiving |
| rd_idx_i | input | 3 | Receive buffer entry to read |
| rd_data_o | output | 8 | Data of the selected entry |
| rd_ferr_o | output | 1 | Framing error of the selected entry |
| rx_count_o | output | 4 | Receive write pointer, the number of stored bytes |
| rx_ovf_o | output | 1 | A byte was dropped because the buffer was full |
| rx_irq_o | output | 1 | One-clock pulse per stored byte |

## Verification
Each internal fault shows at the pins of this block, mostly at one of two moments. If the release logic wrongly drops the request, `line_oe_o` falls in the middle of a character, and a bench that samples every bit of the frame sees a broken frame at once. If it holds the driver too long, `line_oe_o` is still high one clock after the final stop bit. A receiver that is not gated during the block's own transmission shows a nonzero `rx_count_o` right after a send. A bad bit sample point or a bad shift order shows as a wrong `rd_data_o` one bit time after the stop bit. Faults in the pointer or the flags show as a wrong count, a wrong overflow flag or a wrong interrupt count after the byte that triggers them.

// File: rtl/hd_uart_pkg.sv
package hd_uart_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic                 ferr;
    logic [DATA_BITS-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/hd_uart_tx.sv
module hd_uart_tx
  import hd_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 tx_en_i,
  input  logic                 wr_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 full_o,
  output logic                 line_o,
  output logic                 oe_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  logic [DATA_BITS-1:0]  hold_q;
  logic                  hold_vld_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  busy_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  active_q;

  logic bit_end, frame_end, load, accept;

  assign bit_end   = busy_q && (cnt_q == '0);
  assign frame_end = bit_end && (idx_q == LAST_BIT);
  // next byte enters the shifter right as the previous stop bit ends
  assign load      = hold_vld_q && (!busy_q || frame_end);
  assign accept    = wr_i && tx_en_i && !hold_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (accept) begin
      hold_q     <= data_i;
      hold_vld_q <= 1'b1;
    end else if (load) begin
      hold_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (load) begin
      frame_q <= {1'b1, hold_q, 1'b0};
      busy_q  <= 1'b1;
      cnt_q   <= div_i - DIV_W'(1);
      idx_q   <= '0;
    end else if (frame_end) begin
      busy_q  <= 1'b0;
    end else if (bit_end) begin
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
      idx_q   <= idx_q + IDX_W'(1);
      cnt_q   <= div_i - DIV_W'(1);
    end else if (busy_q) begin
      cnt_q   <= cnt_q - DIV_W'(1);
    end
  end

  // disable is deferred: driver holds until holding and shift registers drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= tx_en_i || hold_vld_q || busy_q;
  end

  assign line_o = busy_q ? frame_q[0] : 1'b1;
  assign oe_o   = active_q;
  assign full_o = hold_vld_q;

  AST_QUEUE_KEEPS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld_q || busy_q) |-> active_q); // R3
  AST_RELEASED_IDLES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> line_o); // R4
  AST_STOP_BIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |-> line_o); // R2
  AST_WRITE_WHILE_OFF_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_en_i && !hold_vld_q) |=> !hold_vld_q); // R5
endmodule

// File: rtl/hd_uart_rx.sv
module hd_uart_rx
  import hd_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 en_i,
  input  logic                 line_i,
  output logic                 vld_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o
);
  localparam int unsigned BIT_W = $clog2(DATA_BITS);

  logic [1:0]           sync_q;
  logic                 rx_bit;
  rx_state_e            state_q;
  logic [DIV_W-1:0]     cnt_q;
  logic [BIT_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] sh_q;

  assign rx_bit = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      vld_o   <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: if (!rx_bit) begin
            state_q <= RX_START;
            cnt_q   <= (div_i >> 1) - DIV_W'(1);
          end
          RX_START: if (cnt_q == '0) begin
            if (!rx_bit) begin
              state_q <= RX_DATA;
              cnt_q   <= div_i - DIV_W'(1);
              idx_q   <= '0;
            end else begin
              state_q <= RX_IDLE;   // glitch, not a start bit
            end
          end else cnt_q <= cnt_q - DIV_W'(1);
          RX_DATA: if (cnt_q == '0) begin
            sh_q  <= {rx_bit, sh_q[DATA_BITS-1:1]};
            cnt_q <= div_i - DIV_W'(1);
            if (idx_q == BIT_W'(DATA_BITS - 1)) state_q <= RX_STOP;
            else idx_q <= idx_q + BIT_W'(1);
          end else cnt_q <= cnt_q - DIV_W'(1);
          RX_STOP: if (cnt_q == '0) begin
            vld_o   <= 1'b1;
            data_o  <= sh_q;
            ferr_o  <= !rx_bit;
            state_q <= rx_bit ? RX_IDLE : RX_WAIT_HI;
          end else cnt_q <= cnt_q - DIV_W'(1);
          RX_WAIT_HI: if (rx_bit) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_QUIET_WHEN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE && !vld_o)); // R8
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R11
endmodule

// File: rtl/hd_uart_rxbuf.sv
module hd_uart_rxbuf
  import hd_uart_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  rx_entry_t        entry_i,
  input  logic             irq_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output rx_entry_t        rd_entry_o,
  output logic [PTR_W-1:0] count_o,
  output logic             ovf_o,
  output logic             irq_o
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [PTR_W-1:0] wptr_q;
  logic             ovf_q;
  rx_entry_t        mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && !clr_i && wptr_q == PTR_W'(g)) mem_q[g] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= push_i && irq_en_i && !clr_i;
      if (clr_i) begin
        wptr_q <= '0;
        ovf_q  <= 1'b0;
      end else if (push_i) begin
        if (wptr_q == FULL) ovf_q  <= 1'b1;
        else                wptr_q <= wptr_q + PTR_W'(1);
      end
    end
  end

  assign rd_entry_o = mem_q[rd_idx_i];
  assign count_o    = wptr_q;
  assign ovf_o      = ovf_q;

  AST_PTR_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= FULL); // R13
  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i && wptr_q == FULL) |=> (wptr_q == FULL && ovf_q)); // R13
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q); // R13
  AST_CLEAR_REWINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wptr_q == '0 && !ovf_q)); // R10
endmodule

// File: rtl/hd_uart.sv
module hd_uart
  import hd_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 ctrl_we_i,
  input  logic                 ctrl_tx_en_i,
  input  logic                 ctrl_rx_en_i,
  input  logic                 ctrl_rx_ie_i,
  input  logic                 turn_rx_i,
  input  logic                 tx_wr_i,
  input  logic [DATA_BITS-1:0] tx_data_i,
  output logic                 tx_full_o,
  input  logic                 line_i,
  output logic                 line_o,
  output logic                 line_oe_o,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 rd_ferr_o,
  output logic [PTR_W-1:0]     rx_count_o,
  output logic                 rx_ovf_o,
  output logic                 rx_irq_o
);
  logic tx_en_q, rx_en_q, rx_ie_q;
  logic buf_clr, rx_gate, rx_vld, rx_ferr;
  logic [DATA_BITS-1:0] rx_data;
  rx_entry_t rd_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      rx_ie_q <= 1'b0;
    end else if (turn_rx_i) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b1;
      rx_ie_q <= 1'b1;
    end else if (ctrl_we_i) begin
      tx_en_q <= ctrl_tx_en_i;
      rx_en_q <= ctrl_rx_en_i;
      rx_ie_q <= ctrl_rx_ie_i;
    end
  end

  assign buf_clr = turn_rx_i || (ctrl_we_i && ctrl_rx_en_i && !rx_en_q);
  assign rx_gate = rx_en_q && !line_oe_o;

  hd_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_i),
    .tx_en_i (tx_en_q),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .full_o  (tx_full_o),
    .line_o  (line_o),
    .oe_o    (line_oe_o)
  );

  hd_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .en_i   (rx_gate),
    .line_i (line_i),
    .vld_o  (rx_vld),
    .data_o (rx_data),
    .ferr_o (rx_ferr)
  );

  hd_uart_rxbuf #(.DEPTH(DEPTH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .push_i     (rx_vld),
    .entry_i    ('{ferr: rx_ferr, data: rx_data}),
    .irq_en_i   (rx_ie_q),
    .rd_idx_i   (rd_idx_i),
    .rd_entry_o (rd_entry),
    .count_o    (rx_count_o),
    .ovf_o      (rx_ovf_o),
    .irq_o      (rx_irq_o)
  );

  assign rd_data_o = rd_entry.data;
  assign rd_ferr_o = rd_entry.ferr;

  AST_TURN_SETS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_rx_i |=> (!tx_en_q && rx_en_q && rx_ie_q)); // R10
  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ie_q && !turn_rx_i && !ctrl_we_i) |=> !rx_irq_o); // R11
endmodule

// File: tb/hd_uart_bench.sv
module hd_uart_bench;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] div = 16'(DIV);
  logic ctrl_we = 0, c_tx = 0, c_rx = 0, c_ie = 0, turn = 0;
  logic tx_wr = 0;
  logic [7:0] tx_data = 0;
  logic rem_oe = 0, rem_d = 1;
  logic [2:0] rd_idx = 0;
  logic tx_full, line_o, line_oe, rd_ferr, rx_ovf, rx_irq;
  logic [7:0] rd_data;
  logic [3:0] rx_count;
  logic line;

  int total = 0, bad = 0, irq_cnt = 0;

  always #5 clk = ~clk;

  assign line = line_oe ? line_o : (rem_oe ? rem_d : 1'b1);

  hd_uart u_hd_uart (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div),
    .ctrl_we_i(ctrl_we), .ctrl_tx_en_i(c_tx), .ctrl_rx_en_i(c_rx), .ctrl_rx_ie_i(c_ie),
    .turn_rx_i(turn), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .line_i(line), .line_o(line_o), .line_oe_o(line_oe),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_ferr_o(rd_ferr),
    .rx_count_o(rx_count), .rx_ovf_o(rx_ovf), .rx_irq_o(rx_irq)
  );

  always @(negedge clk) if (rx_irq) irq_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(logic t, logic r, logic i);
    ctrl_we = 1; c_tx = t; c_rx = r; c_ie = i;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wr_byte(logic [7:0] b);
    tx_wr = 1; tx_data = b;
    @(negedge clk);
    tx_wr = 0;
  endtask

  // waits for a start bit driven by the block, samples 10 bits mid-bit,
  // returns at the end of the stop bit
  task automatic capture(output logic [9:0] f, output int waited);
    waited = 0;
    f = '0;
    while (!(line_oe && line_o == 1'b0) && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    tick(DIV / 2);
    f[0] = line_o;
    for (int k = 1; k < 10; k++) begin
      tick(DIV);
      f[k] = line_o;
    end
    tick(DIV - DIV / 2);
  endtask

  task automatic remote_send(logic [7:0] b, logic stop_v);
    rem_oe = 1; rem_d = 0;
    tick(DIV);
    for (int i = 0; i < 8; i++) begin
      rem_d = b[i];
      tick(DIV);
    end
    rem_d = stop_v;
    tick(DIV);
    rem_d = 1; rem_oe = 0;
    tick(DIV);
  endtask

  task automatic read_entry(int idx, logic [7:0] exp_d, logic exp_f, string req);
    rd_idx = 3'(idx);
    #1;
    chk({req, " data"}, rd_data, exp_d);
    chk({req, " ferr"}, rd_ferr, exp_f);
  endtask

  task automatic t_reset;
    chk("R1 oe", line_oe, 0);
    chk("R1 line", line_o, 1);
    chk("R1 full", tx_full, 0);
    chk("R1 count", rx_count, 0);
    chk("R1 irq", rx_irq, 0);
  endtask

  task automatic t_tx_pair;
    logic [9:0] f1, f2;
    int w1, w2;
    set_ctrl(1, 1, 0);
    fork
      begin wr_byte(8'hA5); tick(2); wr_byte(8'h3C); tick(2); set_ctrl(0, 1, 0); end
      begin capture(f1, w1); capture(f2, w2); end
    join
    chk("R2 frame first", f1, {1'b1, 8'hA5, 1'b0});
    chk("R2 frame second", f2, {1'b1, 8'h3C, 1'b0});
    chk("R2 back to back", w2, 0);
    chk("R3 oe held through queue", line_oe, 1);
    tick(1);
    chk("R4 oe falls after stop", line_oe, 0);
    chk("R4 line high released", line_o, 1);
    chk("R8 own bytes not stored", rx_count, 0);
  endtask

  task automatic t_release_idle;
    set_ctrl(1, 1, 0);
    tick(3);
    chk("R4 oe on", line_oe, 1);
    set_ctrl(0, 1, 0);
    chk("R4 oe one clock after clear", line_oe, 1);
    tick(1);
    chk("R4 oe off", line_oe, 0);
  endtask

  task automatic t_ignore_wr;
    int errs = 0;
    wr_byte(8'h00);
    chk("R5 full stays 0", tx_full, 0);
    for (int i = 0; i < 30; i++) begin
      if (line_oe !== 1'b0 || line_o !== 1'b1) errs++;
      tick(1);
    end
    chk("R5 no character", errs, 0);
  endtask

  task automatic t_cancel;
    logic [9:0] f;
    int w;
    set_ctrl(1, 1, 0);
    fork
      wr_byte(8'h96);
      begin tick(3); set_ctrl(0, 1, 0); tick(3); set_ctrl(1, 1, 0); end
      capture(f, w);
    join
    chk("R6 frame", f, {1'b1, 8'h96, 1'b0});
    tick(4);
    chk("R6 release cancelled", line_oe, 1);
    set_ctrl(0, 1, 0);
    tick(2);
    chk("R6 release after clear", line_oe, 0);
  endtask

  task automatic t_rx_basic;
    int base;
    set_ctrl(0, 1, 1);
    base = irq_cnt;
    remote_send(8'h5A, 1);
    remote_send(8'h81, 1);
    chk("R7 count", rx_count, 2);
    read_entry(0, 8'h5A, 0, "R7 entry0");
    read_entry(1, 8'h81, 0, "R7 entry1");
    chk("R11 irq pulses", irq_cnt - base, 2);
  endtask

  task automatic t_rx_off;
    int base;
    set_ctrl(0, 0, 1);
    remote_send(8'h11, 1);
    chk("R9 disabled rx ignores", rx_count, 2);
    set_ctrl(0, 1, 0);
    chk("R10 rx enable rewinds", rx_count, 0);
    base = irq_cnt;
    remote_send(8'h42, 1);
    chk("R7 count after rewind", rx_count, 1);
    read_entry(0, 8'h42, 0, "R7 rewound entry");
    chk("R11 no irq when masked", irq_cnt - base, 0);
  endtask

  task automatic t_ferr;
    remote_send(8'h7E, 0);
    remote_send(8'h24, 1);
    chk("R12 count", rx_count, 3);
    read_entry(1, 8'h7E, 1, "R12 bad stop");
    read_entry(2, 8'h24, 0, "R12 recovery");
  endtask

  task automatic t_ovf;
    for (int i = 0; i < 5; i++) remote_send(8'(8'h30 + i), 1);
    chk("R13 full count", rx_count, 8);
    chk("R13 no ovf yet", rx_ovf, 0);
    remote_send(8'hEE, 1);
    remote_send(8'hDD, 1);
    chk("R13 saturated", rx_count, 8);
    chk("R13 ovf set", rx_ovf, 1);
    read_entry(7, 8'h34, 0, "R13 last kept");
  endtask

  task automatic t_turn;
    logic [9:0] f;
    int w, base;
    set_ctrl(1, 1, 0);
    fork
      wr_byte(8'hC3);
      begin tick(2); turn = 1; @(negedge clk); turn = 0; end
      capture(f, w);
    join
    chk("R10 frame completes", f, {1'b1, 8'hC3, 1'b0});
    chk("R3 oe held after turn", line_oe, 1);
    tick(1);
    chk("R4 oe off after turn", line_oe, 0);
    chk("R10 count cleared", rx_count, 0);
    chk("R10 ovf cleared", rx_ovf, 0);
    wr_byte(8'h55);
    tick(1);
    chk("R10 tx disabled", tx_full, 0);
    chk("R10 no drive", line_oe, 0);
    base = irq_cnt;
    remote_send(8'h6B, 1);
    chk("R10 rx enabled", rx_count, 1);
    read_entry(0, 8'h6B, 0, "R10 reply");
    chk("R10 irq enabled", irq_cnt - base, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_tx_pair();
    t_release_idle();
    t_ignore_wr();
    t_cancel();
    t_rx_basic();
    t_rx_off();
    t_ferr();
    t_ovf();
    t_turn();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule